// File: doc/BRIEF.md
# Dual-Width Paged ROM Read Port

This block is a cycle-based model of a read-only memory read port. It can be strapped for 16-bit word reads or 8-bit byte reads. A chip enable and an output enable gate the port. In word mode the top data lane is bit 15 of the word. In byte mode that same pin becomes an extra low address input, `top_in`, which picks the upper or lower half of the addressed word. That half is then delivered on the lower eight lanes. Each output lane carries an enable flag in place of a tri-state driver, and a `data_valid` strobe marks the cycles in which the bus holds good data.

Access time is counted in clock cycles. A cold access pays the full latency. While the chip stays enabled and only the in-page address bits move, the port answers on a shortened page path. An identifier mode returns fixed manufacturer and device words, each with odd parity. The array contents are computed at elaboration time from a fixed formula.

Top module: `paged_rom_port`

## Requirements
- R1: While `chip_en` is low, the next clock edge leaves `lane_en` = 2'b00, `data_valid` = 0 and `rd_data` = 0, whatever `out_en` does. The same values hold after reset.
- R2: While `chip_en` is high and `out_en` is low, the next edge leaves `lane_en` = 2'b00 and `data_valid` = 0. If `out_en` returns high and the address has not changed, the data comes back one edge later.
- R3: In word mode (`byte_mode` = 0), a valid read gives `lane_en` = 2'b11, and `rd_data` holds the whole addressed word.
- R4: In byte mode (`byte_mode` = 1), a valid read gives `lane_en` = 2'b01 and `rd_data[15:8]` = 0. `rd_data[7:0]` holds word bits 15..8 when `top_in` = 1 and word bits 7..0 when `top_in` = 0.
- R5: The word at address a holds (a*40503 + 4660) mod 65536.
- R6: A cold access gives `data_valid` after FULL_LAT (default 4) rising edges with stable inputs. An access is cold when `chip_en` was low on the previous edge, or when an address bit above bit PAGE_W-1 changed, or when `byte_mode` or `id_mode` changed.
- R7: A page hit gives `data_valid` after PAGE_LAT (default 2) edges. A page hit is a read where the previous access has completed, `chip_en` stayed high, and only `addr[PAGE_W-1:0]` changed, or `top_in` as well in byte mode.
- R8: In word mode, `top_in` is ignored. Toggling it while data is valid keeps `data_valid` high and `rd_data` unchanged.
- R9: With `id_mode` = 1 and all address bits other than bit 0 zero, the word read is 16'h00C2 when `addr[0]` = 0 and 16'hB816 when `addr[0]` = 1. Lane steering follows R3/R4 and timing follows R6/R7.
- R10: In word mode, each identifier word read has odd parity over its 16 bits, with bit 15 as the parity bit.
- R11: If `chip_en` and `id_mode` are high and any bit of `addr[ADDR_W-1:1]` is set, the next edge raises `id_err` and disables all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, high active |
| out_en | input | 1 | Output enable, high active |
| byte_mode | input | 1 | Width strap: 1 selects byte reads |
| addr | input | ADDR_W | Word address |
| top_in | input | 1 | Byte-select low address input, used in byte mode only |
| id_mode | input | 1 | Identifier readout request |
| rd_data | output | 16 | Read data bus |
| lane_en | output | 2 | Lane drive enables: bit 0 for lanes 7..0, bit 1 for lanes 15..8 |
| data_valid | output | 1 | Read data valid |
| id_err | output | 1 | Identifier request made with a bad address |

## Verification
On every cycle, the assertions check that the port goes quiet for standby and for output disable. They also check that the upper lanes are never driven in byte mode, that all lanes are driven for word reads, that identifier words keep odd parity, and that a bad identifier address raises the error with the lanes off. Only the bench scenarios can show the exact cycle counts that separate cold accesses from page hits. The same holds for the computed array contents, for byte-half selection and for the two identifier values. The bench also shows that `top_in` has no effect in word mode, and that re-enabling the outputs on an unchanged address is fast.

// File: rtl/rom_port_pkg.sv
package rom_port_pkg;
  localparam logic [15:0] MFR_WORD = 16'h00C2;
  localparam logic [15:0] DEV_WORD = 16'hB816;

  // array content rule: (a*40503 + 4660) mod 2^16
  function automatic logic [15:0] rom_word(input int unsigned a);
    logic [31:0] t;
    t = a * 32'd40503 + 32'd4660;
    return t[15:0];
  endfunction
endpackage

// File: rtl/rom_array.sv
module rom_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_word
);
  import rom_port_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(i);
  end

  always_ff @(posedge clk) rd_word <= mem[rd_addr];
endmodule

// File: rtl/access_timer.sv
module access_timer #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 3,
  parameter int FULL_LAT = 4,
  parameter int PAGE_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              id_mode,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              top_in,
  output logic              ready
);
  localparam int CW = $clog2(FULL_LAT + 1);
  localparam logic [CW-1:0] FULL_LOAD = CW'(FULL_LAT - 1);
  localparam logic [CW-1:0] PAGE_LOAD = CW'(PAGE_LAT - 1);

  logic              ce_q, id_q, bm_q, top_q, open_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              changed, same_page, hit;

  assign changed   = !ce_q || (addr != addr_q) || (id_mode != id_q) ||
                     (byte_mode != bm_q) || (byte_mode && (top_in != top_q));
  assign same_page = (addr[ADDR_W-1:PAGE_W] == addr_q[ADDR_W-1:PAGE_W]) &&
                     (id_mode == id_q) && (byte_mode == bm_q);
  assign hit       = open_q && same_page;

  always_comb begin
    if (!chip_en)                cnt_d = FULL_LOAD;
    else if (changed)            cnt_d = hit ? PAGE_LOAD : FULL_LOAD;
    else if (cnt_q != '0)        cnt_d = cnt_q - 1'b1;
    else                         cnt_d = '0;
  end

  assign ready = chip_en && (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      id_q   <= 1'b0;
      bm_q   <= 1'b0;
      top_q  <= 1'b0;
      addr_q <= '0;
      open_q <= 1'b0;
      cnt_q  <= FULL_LOAD;
    end else begin
      ce_q   <= chip_en;
      id_q   <= id_mode;
      bm_q   <= byte_mode;
      top_q  <= top_in;
      addr_q <= addr;
      open_q <= ready;
      cnt_q  <= cnt_d;
    end
  end

  // R6: a cold start never completes on the same edge
  a_r6_cold_not_ready: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !ce_q) |-> !ready);
  // R7: the page path never has an open page after standby
  a_r7_page_closed: assert property (@(posedge clk) disable iff (rst)
    (!chip_en) |=> !open_q);
endmodule

// File: rtl/lane_steer.sv
module lane_steer (
  input  logic        clk,
  input  logic        rst,
  input  logic        ready,
  input  logic        chip_en,
  input  logic        out_en,
  input  logic        bad_id,
  input  logic        byte_mode,
  input  logic        top_in,
  input  logic        id_mode,
  input  logic        addr0,
  input  logic [15:0] mem_word,
  output logic [15:0] rd_data,
  output logic [1:0]  lane_en,
  output logic        data_valid
);
  import rom_port_pkg::*;

  logic        on;
  logic [15:0] word;
  logic [7:0]  half;

  assign on   = ready && out_en && !bad_id;
  assign word = id_mode ? (addr0 ? DEV_WORD : MFR_WORD) : mem_word;
  assign half = top_in ? word[15:8] : word[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      lane_en    <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= on;
      lane_en    <= !on ? 2'b00 : (byte_mode ? 2'b01 : 2'b11);
      rd_data    <= !on ? 16'h0 : (byte_mode ? {8'h00, half} : word);
    end
  end

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    (!chip_en) |=> (lane_en == 2'b00 && !data_valid && rd_data == 16'h0));
  a_r2_output_off: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !out_en) |=> (lane_en == 2'b00 && !data_valid));
  a_r4_upper_off: assert property (@(posedge clk) disable iff (rst)
    (byte_mode) |=> (!lane_en[1] && rd_data[15:8] == 8'h00));
endmodule

// File: rtl/paged_rom_port.sv
module paged_rom_port #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 3,
  parameter int FULL_LAT = 4,
  parameter int PAGE_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              out_en,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              top_in,
  input  logic              id_mode,
  output logic [15:0]       rd_data,
  output logic [1:0]        lane_en,
  output logic              data_valid,
  output logic              id_err
);
  initial begin
    if (PAGE_LAT < 2 || FULL_LAT < PAGE_LAT || PAGE_W >= ADDR_W)
      $error("paged_rom_port: bad latency or page parameters");
  end

  logic [15:0] mem_word;
  logic        ready, bad_id;

  assign bad_id = chip_en && id_mode && (addr[ADDR_W-1:1] != '0);

  rom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rd_addr(addr), .rd_word(mem_word)
  );

  access_timer #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)
  ) u_timer (
    .clk(clk), .rst(rst), .chip_en(chip_en), .id_mode(id_mode),
    .byte_mode(byte_mode), .addr(addr), .top_in(top_in), .ready(ready)
  );

  lane_steer u_steer (
    .clk(clk), .rst(rst), .ready(ready), .chip_en(chip_en), .out_en(out_en),
    .bad_id(bad_id), .byte_mode(byte_mode), .top_in(top_in),
    .id_mode(id_mode), .addr0(addr[0]), .mem_word(mem_word),
    .rd_data(rd_data), .lane_en(lane_en), .data_valid(data_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) id_err <= 1'b0;
    else     id_err <= bad_id;
  end

  a_r3_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (chip_en && out_en && !byte_mode) |=> (!data_valid || lane_en == 2'b11));
  a_r10_id_parity: assert property (@(posedge clk) disable iff (rst)
    (chip_en && id_mode && !byte_mode && !bad_id) |=> (!data_valid || ^rd_data));
  a_r11_bad_id: assert property (@(posedge clk) disable iff (rst)
    (bad_id) |=> (id_err && lane_en == 2'b00 && !data_valid));
endmodule

// File: tb/test_paged_rom_port.sv
module test_paged_rom_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;

  logic clk = 0, rst = 1;
  logic chip_en = 0, out_en = 0, byte_mode = 0, top_in = 0, id_mode = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  lane_en;
  logic        data_valid, id_err;

  int checks = 0, errors = 0;

  typedef struct {
    logic [15:0] d;
    logic [1:0]  ln;
    int          lat;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  int cyc = 0;
  bit armed = 0, seen = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_rom_port #(.ADDR_W(ADDR_W)) i_paged_rom_port (
    .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en),
    .byte_mode(byte_mode), .addr(addr), .top_in(top_in), .id_mode(id_mode),
    .rd_data(rd_data), .lane_en(lane_en), .data_valid(data_valid), .id_err(id_err)
  );

  function automatic logic [15:0] model_word(input int a);
    logic [31:0] t;
    t = a * 32'd40503 + 32'd4660;
    return t[15:0];
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // monitor: counts edges since the stimulus, pops the scoreboard on the first valid
  always @(posedge clk) if (armed) cyc++;
  always @(negedge clk) begin
    if (armed && cyc > 0 && data_valid && !seen) begin
      seen = 1;
      if (exp_q.size() == 0) begin
        check(0, "SB", "unexpected data", rd_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rd_data == e.d, e.rq, "data", rd_data, e.d);
        check(lane_en == e.ln, e.rq, "lanes", lane_en, e.ln);
        check(cyc == e.lat, e.rq, "latency", cyc, e.lat);
      end
      done = 1;
    end
  end

  task automatic drive(input logic c, input logic o, input logic b,
                       input int a, input logic t, input logic i);
    @(posedge clk); #1;
    chip_en = c; out_en = o; byte_mode = b; addr = ADDR_W'(a);
    top_in = t; id_mode = i;
    cyc = 0; seen = 0; done = 0;
  endtask

  task automatic read_exp(input logic c, input logic o, input logic b,
                          input int a, input logic t, input logic i,
                          input logic [15:0] d, input logic [1:0] ln,
                          input int lat, input string rq);
    exp_t e;
    e.d = d; e.ln = ln; e.lat = lat; e.rq = rq;
    exp_q.push_back(e);
    drive(c, o, b, a, t, i);
    armed = 1;
    for (int k = 0; k < 12 && !done; k++) @(negedge clk);
    if (!done) begin
      check(0, rq, "no data_valid", 0, 1);
      void'(exp_q.pop_front());
    end
    armed = 0;
  endtask

  task automatic off_exp(input logic c, input logic o, input logic b,
                         input int a, input logic t, input logic i,
                         input logic err, input string rq);
    drive(c, o, b, a, t, i);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(data_valid == 0, rq, "data_valid", data_valid, 0);
    check(lane_en == 2'b00, rq, "lanes", lane_en, 0);
    check(id_err == err, rq, "id_err", id_err, err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    check(data_valid == 0 && lane_en == 0 && rd_data == 0 && id_err == 0,
          "R1", "reset outputs", {lane_en, data_valid}, 0);

    // R6 R3 R5: cold word read
    read_exp(1, 1, 0, 'h010, 0, 0, model_word('h010), 2'b11, 4, "R6");
    // R7: page hits
    read_exp(1, 1, 0, 'h013, 0, 0, model_word('h013), 2'b11, 2, "R7");
    read_exp(1, 1, 0, 'h015, 0, 0, model_word('h015), 2'b11, 2, "R7");
    // R6: upper bits change
    read_exp(1, 1, 0, 'h01D, 0, 0, model_word('h01D), 2'b11, 4, "R6");

    // R8: top_in ignored in word mode
    drive(1, 1, 0, 'h01D, 1, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(data_valid == 1, "R8", "valid kept", data_valid, 1);
    check(rd_data == model_word('h01D), "R8", "data kept", rd_data, model_word('h01D));

    // R4: byte mode, low then high half
    w = model_word('h01D);
    read_exp(1, 1, 1, 'h01D, 0, 0, {8'h00, w[7:0]}, 2'b01, 4, "R4");
    read_exp(1, 1, 1, 'h01D, 1, 0, {8'h00, w[15:8]}, 2'b01, 2, "R4");
    w = model_word('h01A);
    read_exp(1, 1, 1, 'h01A, 0, 0, {8'h00, w[7:0]}, 2'b01, 2, "R7");

    // R2: output disable then re-enable on same address
    off_exp(1, 0, 1, 'h01A, 0, 0, 0, "R2");
    read_exp(1, 1, 1, 'h01A, 0, 0, {8'h00, w[7:0]}, 2'b01, 1, "R2");

    // R1: standby with out_en high
    off_exp(0, 1, 0, 'h01A, 0, 0, 0, "R1");
    @(negedge clk);
    check(rd_data == 16'h0, "R1", "data zero", rd_data, 0);

    // R5: last address, cold after standby
    read_exp(1, 1, 0, 'h3FF, 0, 0, model_word('h3FF), 2'b11, 4, "R5");

    // R9 R10: identifier words
    read_exp(1, 1, 0, 0, 0, 1, 16'h00C2, 2'b11, 4, "R9");
    check($countones(rd_data) % 2 == 1, "R10", "mfr parity", rd_data, 16'h00C2);
    read_exp(1, 1, 0, 1, 0, 1, 16'hB816, 2'b11, 2, "R9");
    check($countones(rd_data) % 2 == 1, "R10", "dev parity", rd_data, 16'hB816);
    read_exp(1, 1, 1, 1, 1, 1, 16'h00B8, 2'b01, 4, "R9");

    // R11: bad identifier address
    off_exp(1, 1, 0, 'h005, 0, 1, 1, "R11");
    read_exp(1, 1, 0, 'h005, 0, 0, model_word('h005), 2'b11, 4, "R11");
    check(id_err == 0, "R11", "id_err cleared", id_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule